// File: doc/BRIEF.md
# Accumulator Machine Control and Branch Unit

This block is the control heart of a small two-register accumulator processor that executes one 16-bit instruction word per clock. It splits each word into one of two classes. An address/constant word loads register A. A compute word drives the six ALU control lines and picks the ALU's second operand. It also chooses which of register A, register D and the memory port receive the result. Its jump mask is tested against the ALU status flags.

The unit owns the 15-bit program counter. On every clock the counter either returns to zero under reset, takes the low bits of register A when a jump is taken, or advances by one. The ALU, the register contents and the memories sit outside the block. The surrounding datapath feeds back the A register value and the zero and negative flags of the current ALU result. The decoded control outputs are combinational from the instruction word, so they act in the cycle in which the word is presented.

Top module: `acc_ctl_unit`

## Requirements
- R1: A word with bit 15 = 0 is an address/constant word. It sets `a_load`=1 and `a_src_instr`=1, with `d_load`=0, `mem_wr`=0, `alu_ctl`=0 and `opnd_mem`=0.
- R2: For a word with bit 15 = 1, `opnd_mem` equals bit 12 (1 = memory input, 0 = register A). `alu_ctl[5:0]` carries bits 11..6 in the order zx, nx, zy, ny, f, no, with zx on `alu_ctl[5]`.
- R3: For a compute word, bit 5 drives `a_load`, bit 4 drives `d_load` and bit 3 drives `mem_wr`. All eight combinations are honoured, and `a_src_instr`=0.
- R4: For a compute word, bits 2..0 form a mask: bit 2 = result less than zero, bit 1 = equal to zero, bit 0 = greater than zero. The result is negative when `ng_flag`=1, zero when `zr_flag`=1, and positive when both flags are 0. The jump is taken when the mask bit of the current condition is set, so 000 never jumps and 111 always jumps.
- R5: A taken jump loads `pc` with the low 15 bits of `a_val` at the next rising clock edge.
- R6: When no jump is taken and reset is low, `pc` increments by one per clock, wrapping from 0x7FFF to 0.
- R7: An address/constant word never causes a jump, whatever its low three bits are.
- R8: Synchronous active-high reset `rst` clears `pc` to 0 and takes priority over a taken jump.
- R9: The word 0xEC10 (D=A) decodes to `alu_ctl`=110000, `opnd_mem`=0, `d_load`=1, `a_load`=0, `mem_wr`=0, and no jump.
- R10: `mem_wr` is 1 only for a compute word whose bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Current instruction word |
| a_val | input | 16 | Current register A value |
| zr_flag | input | 1 | ALU result is all zeros |
| ng_flag | input | 1 | ALU result MSB |
| alu_ctl | output | 6 | ALU controls {zx,nx,zy,ny,f,no} |
| opnd_mem | output | 1 | ALU second operand: 1 memory, 0 register A |
| a_load | output | 1 | Register A load enable |
| d_load | output | 1 | Register D load enable |
| a_src_instr | output | 1 | Register A source: 1 instruction word, 0 ALU result |
| mem_wr | output | 1 | Memory write strobe |
| pc | output | 15 | Program counter |

## Verification
Reset and a taken jump can arrive on the same clock edge. The bench presents an unconditional-jump compute word with a non-zero `a_val` while `rst` is high. It then judges that `pc` reads zero after the edge and not the jump target. A second collision is an address word whose low three bits are all ones, given with flags that would satisfy any mask. The counter must still only advance by one.

// File: rtl/acc_ctl_pkg.sv
package acc_ctl_pkg;
  localparam int INSTR_W  = 16;
  localparam int CLASS_B  = 15;
  localparam int OPND_B   = 12;
  localparam int ALU_HI   = 11;
  localparam int ALU_W    = 6;
  localparam int DEST_HI  = 5;
  localparam int DEST_W   = 3;
  localparam int JMP_W    = 3;

  typedef struct packed {
    logic zx;
    logic nx;
    logic zy;
    logic ny;
    logic f;
    logic no;
  } alu_ctl_t;

  typedef struct packed {
    logic to_a;
    logic to_d;
    logic to_m;
  } dest_t;

  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
  } jmask_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_ctl_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic               is_comp,
  output logic [ALU_W-1:0]   alu_ctl,
  output logic               opnd_mem,
  output logic               a_load,
  output logic               d_load,
  output logic               a_src_instr,
  output logic               mem_wr,
  output logic [JMP_W-1:0]   jmask
);
  localparam int DEST_LO = DEST_HI - DEST_W + 1;
  localparam int ALU_LO  = ALU_HI - ALU_W + 1;

  alu_ctl_t ctl;
  dest_t    dst;

  always_comb begin
    is_comp = instr[CLASS_B];
    ctl     = alu_ctl_t'(instr[ALU_HI:ALU_LO]);
    dst     = dest_t'(instr[DEST_HI:DEST_LO]);
    if (is_comp) begin
      alu_ctl     = ctl;
      opnd_mem    = instr[OPND_B];
      a_load      = dst.to_a;
      d_load      = dst.to_d;
      mem_wr      = dst.to_m;
      a_src_instr = 1'b0;
      jmask       = instr[JMP_W-1:0];
    end else begin
      alu_ctl     = '0;
      opnd_mem    = 1'b0;
      a_load      = 1'b1;
      d_load      = 1'b0;
      mem_wr      = 1'b0;
      a_src_instr = 1'b1;
      jmask       = '0;
    end
  end
endmodule

// File: rtl/acc_jump.sv
module acc_jump
  import acc_ctl_pkg::*;
(
  input  logic             is_comp,
  input  logic [JMP_W-1:0] jmask,
  input  logic             zr_flag,
  input  logic             ng_flag,
  output logic             take
);
  jmask_t m;
  logic   pos;

  always_comb begin
    m    = jmask_t'(jmask);
    pos  = ~zr_flag & ~ng_flag;
    take = is_comp & ((m.lt & ng_flag) | (m.eq & zr_flag) | (m.gt & pos));
  end
endmodule

// File: rtl/acc_pc.sv
module acc_pc #(
  parameter int PC_W = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc
);
  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (take) pc <= target;
    else           pc <= pc + PC_ONE;
  end

  // R5: a taken jump lands on the target
  a_r5_jump_target: assert property (@(posedge clk) disable iff (rst)
    take |=> pc == $past(target));

  // R6: otherwise the counter steps by one (with wrap)
  a_r6_step: assert property (@(posedge clk) disable iff (rst)
    !take |=> pc == $past(pc) + PC_ONE);
endmodule

// File: rtl/acc_ctl_unit.sv
module acc_ctl_unit
  import acc_ctl_pkg::*;
#(
  parameter int PC_W = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr,
  input  logic [INSTR_W-1:0] a_val,
  input  logic               zr_flag,
  input  logic               ng_flag,
  output logic [ALU_W-1:0]   alu_ctl,
  output logic               opnd_mem,
  output logic               a_load,
  output logic               d_load,
  output logic               a_src_instr,
  output logic               mem_wr,
  output logic [PC_W-1:0]    pc
);
  logic             is_comp;
  logic [JMP_W-1:0] jmask;
  logic             take;

  acc_decode u_dec (
    .instr       (instr),
    .is_comp     (is_comp),
    .alu_ctl     (alu_ctl),
    .opnd_mem    (opnd_mem),
    .a_load      (a_load),
    .d_load      (d_load),
    .a_src_instr (a_src_instr),
    .mem_wr      (mem_wr),
    .jmask       (jmask)
  );

  acc_jump u_jmp (
    .is_comp (is_comp),
    .jmask   (jmask),
    .zr_flag (zr_flag),
    .ng_flag (ng_flag),
    .take    (take)
  );

  acc_pc #(.PC_W(PC_W)) u_pc (
    .clk    (clk),
    .rst    (rst),
    .take   (take),
    .target (a_val[PC_W-1:0]),
    .pc     (pc)
  );

  // R1: address word writes A from the instruction and nothing else
  a_r1_addr_only_a: assert property (@(posedge clk) disable iff (rst)
    !instr[CLASS_B] |-> a_load && a_src_instr && !d_load && !mem_wr);

  // R10: memory is written only by compute words
  a_r10_wr_compute: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> instr[CLASS_B]);

  // R7: address words never jump
  a_r7_addr_no_jump: assert property (@(posedge clk) disable iff (rst)
    !instr[CLASS_B] |-> !take);

  // R4: an all-ones mask on a compute word always jumps
  a_r4_always: assert property (@(posedge clk) disable iff (rst)
    (instr[CLASS_B] && instr[JMP_W-1:0] == '1) |-> take);
endmodule

// File: tb/test_acc_ctl_unit.sv
module test_acc_ctl_unit;
  localparam int CLK_P = 10;
  localparam int PC_W  = 15;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] instr, a_val;
  logic        zr_flag, ng_flag;
  logic [5:0]  alu_ctl;
  logic        opnd_mem, a_load, d_load, a_src_instr, mem_wr;
  logic [14:0] pc;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [14:0] pc_exp;

  always #(CLK_P/2) clk = ~clk;

  acc_ctl_unit #(.PC_W(PC_W)) i_acc_ctl_unit (
    .clk(clk), .rst(rst), .instr(instr), .a_val(a_val),
    .zr_flag(zr_flag), .ng_flag(ng_flag), .alu_ctl(alu_ctl),
    .opnd_mem(opnd_mem), .a_load(a_load), .d_load(d_load),
    .a_src_instr(a_src_instr), .mem_wr(mem_wr), .pc(pc)
  );

  function automatic logic [15:0] mk_c(input logic a, input logic [5:0] c,
                                       input logic [2:0] d, input logic [2:0] j);
    return {3'b111, a, c, d, j};
  endfunction

  function automatic bit exp_take(input logic [15:0] w, input logic z, input logic n);
    if (!w[15]) return 1'b0;
    if (n)      return w[2];
    if (z)      return w[1];
    return w[0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    bit t;
    t = exp_take(instr, zr_flag, ng_flag);
    @(posedge clk);
    if (rst)    pc_exp = '0;
    else if (t) pc_exp = a_val[14:0];
    else        pc_exp = pc_exp + 15'd1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1; instr = mk_c(0, 6'b101010, 3'b000, 3'b111);
    a_val = 16'h1234; zr_flag = 0; ng_flag = 0;
    step();
    step();
    chk("R8 reset beats jump", pc, 15'd0);
    rst = 0;
  endtask

  task automatic t_addr();
    instr = 16'h7FFF; a_val = 16'h0555; zr_flag = 1; ng_flag = 1;
    #1;
    chk("R1 a_load", a_load, 1);
    chk("R1 a_src_instr", a_src_instr, 1);
    chk("R1 d_load", d_load, 0);
    chk("R1 mem_wr", mem_wr, 0);
    chk("R1 alu_ctl", alu_ctl, 0);
    chk("R1 opnd_mem", opnd_mem, 0);
    step();
    chk("R7 addr word no jump", pc, pc_exp);
    zr_flag = 0; ng_flag = 0;
    step();
    chk("R7 addr word no jump pos", pc, pc_exp);
  endtask

  task automatic t_da();
    instr = 16'hEC10; a_val = 16'h0042; zr_flag = 0; ng_flag = 0;
    #1;
    chk("R9 alu_ctl", alu_ctl, 6'b110000);
    chk("R9 opnd_mem", opnd_mem, 0);
    chk("R9 d_load", d_load, 1);
    chk("R9 a_load", a_load, 0);
    chk("R9 mem_wr", mem_wr, 0);
    step();
    chk("R9 no jump", pc, pc_exp);
  endtask

  task automatic t_dest();
    for (int d = 0; d < 8; d++) begin
      instr = mk_c(d[0], 6'b001100, d[2:0], 3'b000);
      #1;
      chk("R3 a_load", a_load, d[2]);
      chk("R3 d_load", d_load, d[1]);
      chk("R10 mem_wr", mem_wr, d[0]);
      chk("R3 a_src_instr", a_src_instr, 0);
      step();
    end
  endtask

  task automatic t_alu();
    for (int k = 0; k < 6; k++) begin
      logic [5:0] c;
      c = 6'(1 << k);
      instr = mk_c(k[0], c, 3'b010, 3'b000);
      #1;
      chk("R2 alu_ctl", alu_ctl, c);
      chk("R2 opnd_mem", opnd_mem, k[0]);
      step();
    end
  endtask

  task automatic t_jump();
    for (int j = 0; j < 8; j++) begin
      for (int f = 0; f < 3; f++) begin
        instr = mk_c(0, 6'b001100, 3'b000, j[2:0]);
        zr_flag = (f == 1); ng_flag = (f == 2);
        a_val = 16'h8000 | 16'(j * 40 + f * 7 + 100);
        step();
        chk("R4 R5 jump mask", pc, pc_exp);
      end
    end
  endtask

  task automatic t_wrap();
    instr = mk_c(0, 6'b111111, 3'b000, 3'b111); a_val = 16'hFFFF;
    zr_flag = 0; ng_flag = 0;
    step();
    chk("R5 jump to top", pc, 15'h7FFF);
    instr = mk_c(0, 6'b111111, 3'b000, 3'b000);
    step();
    chk("R6 wrap to zero", pc, 15'd0);
    step();
    chk("R6 increment", pc, 15'd1);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    pc_exp = '0;
    rst = 1; instr = '0; a_val = '0; zr_flag = 0; ng_flag = 0;
    @(negedge clk);
    t_reset();
    t_addr();
    t_da();
    t_dest();
    t_alu();
    t_jump();
    t_wrap();
    rst = 1; instr = mk_c(0, 6'b0, 3'b0, 3'b111); a_val = 16'h0ABC;
    step();
    chk("R8 reset mid-run", pc, 15'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule